// File: doc/BRIEF.md
# Instruction Fetch Address Translation Checker

This unit sits between instruction fetch and the instruction TLB. Each cycle that a fetch request is presented, it runs the fetch virtual address through a fixed chain of checks and either produces a physical address or names the first check that failed. The chain, in order, is: hypervisor bypass, alignment, optional truncation to a 32-bit address, virtual-address range, TLB lookup and page privilege.

The TLB is external to the unit. The unit drives a lookup key with a valid strobe and reads back a hit flag, the page frame, the page offset mask and the page privilege bit in the same cycle. The result is registered and appears one cycle after the request.

On any fault the unit also records a packed fault status word. That word keeps its value until the next fault or reset, so trap software can read the context of the most recent failure.

Top module: `ifetch_xlate`

## Requirements
- R1: When bit 2 or bit 5 of `hyp_state` is set, the result is the fetch address truncated to `PA_W` bits with fault code 0. This holds even when the address is misaligned or out of range, and no TLB lookup is requested (`tlb_req_valid` low).
- R2: Outside bypass, a fetch address with non-zero bits [2:0] gives fault code 1 (misaligned). The status word then records fault type 8 (other) with the side-effect flag clear.
- R3: With `addr_mask_en` high, address bits [63:32] are cleared before the range check, and `tlb_req_va` carries the cleared address.
- R4: An address whose bits [63:47] are not all equal gives fault code 2 (out of range). The status word records fault type 2 with the side-effect flag set.
- R5: When the TLB is consulted and `tlb_hit` is low, the result is fault code 3 (TLB miss) and the status word records fault type 4.
- R6: On a TLB hit with `tlb_priv` high and `priv_mode` low, the result is fault code 4 (privilege violation) and the status word records fault type 1. With `priv_mode` high the same page translates normally.
- R7: On success the physical address is `(tlb_pa & ~tlb_off_mask) | (req_va[PA_W-1:0] & tlb_off_mask)`. The offset comes from the unmasked request address.
- R8: The status word has the write flag at bit 2 (always 0 for fetch), `ctx_type` at bits [5:4], the side-effect flag at bit 6, the fault type at bits [13:7] and `asi` at bits [23:16]. All other bits are 0.
- R9: Checks are taken in the order bypass, alignment, range, TLB hit, privilege. Only the first failing check determines the fault code and the status word.
- R10: The status word is 0 after reset. It changes only on a request that faults, and holds through successful requests and idle cycles.
- R11: `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high. `rsp_fault` uses 0 none, 1 misaligned, 2 out of range, 3 TLB miss, 4 privilege violation. `rsp_pa` reads 0 on a faulting response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_va | input | VA_W | Fetch virtual address |
| hyp_state | input | 8 | Hypervisor state word (bits 2 and 5 force bypass) |
| priv_mode | input | 1 | Fetch is privileged |
| addr_mask_en | input | 1 | Truncate address to 32 bits |
| ctx_type | input | 2 | Context type recorded on fault |
| asi | input | 8 | Address space identifier recorded on fault |
| tlb_req_valid | output | 1 | TLB lookup requested |
| tlb_req_va | output | VA_W | Lookup key (masked address) |
| tlb_hit | input | 1 | TLB hit |
| tlb_pa | input | PA_W | Page frame address |
| tlb_off_mask | input | PA_W | Page offset mask |
| tlb_priv | input | 1 | Page is privileged-only |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 3 | Fault code |
| rsp_pa | output | PA_W | Physical address |
| fsr | output | 24 | Fault status word |

## Verification
The hardest situations to reach are the ones where several checks fail at once. Examples are a misaligned address that is also out of range, or a TLB miss on a page that is also privileged. In these cases the priority order alone decides the outcome. The bench drives these overlaps on purpose, and also drives bypass with deliberately bad addresses. It then sweeps random mixtures in which the top address bits are drawn from a few patterns (all zero, all one, broken sign run), so that the range check both passes and fails often. A behavioural reference model predicts every response and every status word.

// File: rtl/ixl_pkg.sv
package ixl_pkg;
  localparam int CTX_W = 2;
  localparam int ASI_W = 8;
  localparam int FT_W  = 7;
  localparam int FSR_WR_BIT  = 2;
  localparam int FSR_CTX_LSB = 4;
  localparam int FSR_SE_BIT  = 6;
  localparam int FSR_FT_LSB  = 7;
  localparam int FSR_ASI_LSB = 16;
  localparam int FSR_W = FSR_ASI_LSB + ASI_W;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_MISALIGN = 3'd1,
    FLT_RANGE    = 3'd2,
    FLT_MISS     = 3'd3,
    FLT_PRIV     = 3'd4
  } fault_e;

  localparam logic [FT_W-1:0] FT_PRIVV  = 7'd1;
  localparam logic [FT_W-1:0] FT_RANGEV = 7'd2;
  localparam logic [FT_W-1:0] FT_MISSV  = 7'd4;
  localparam logic [FT_W-1:0] FT_OTHER  = 7'd8;

  function automatic logic [FT_W-1:0] ftype_of(fault_e f);
    case (f)
      FLT_MISALIGN: return FT_OTHER;
      FLT_RANGE:    return FT_RANGEV;
      FLT_MISS:     return FT_MISSV;
      FLT_PRIV:     return FT_PRIVV;
      default:      return '0;
    endcase
  endfunction

  function automatic logic se_of(fault_e f);
    return (f == FLT_RANGE);
  endfunction

  function automatic logic [FSR_W-1:0] fsr_pack(logic [CTX_W-1:0] ctx,
                                               fault_e f,
                                               logic [ASI_W-1:0] asi_v);
    logic [FSR_W-1:0] w;
    w = '0;
    w[FSR_WR_BIT] = 1'b0;
    w[FSR_CTX_LSB +: CTX_W] = ctx;
    w[FSR_SE_BIT] = se_of(f);
    w[FSR_FT_LSB +: FT_W] = ftype_of(f);
    w[FSR_ASI_LSB +: ASI_W] = asi_v;
    return w;
  endfunction
endpackage

// File: rtl/ixl_precheck.sv
module ixl_precheck #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int ALIGN_B = 3,
  parameter int MASK_W  = 32
) (
  input  logic [VA_W-1:0] va,
  input  logic [7:0]      hyp_state,
  input  logic            addr_mask_en,
  output logic            bypass,
  output logic            misalign,
  output logic            out_of_range,
  output logic [VA_W-1:0] eff_va
);
  localparam int TOP_W = VA_W - VA_IMPL + 1;

  function automatic logic [VA_W-1:0] trunc_va(logic [VA_W-1:0] v, logic en);
    logic [VA_W-1:0] r;
    r = v;
    if (en) r[VA_W-1:MASK_W] = '0;
    return r;
  endfunction

  function automatic logic sign_run_ok(logic [VA_W-1:0] v);
    logic [TOP_W-1:0] top;
    top = v[VA_W-1:VA_IMPL-1];
    return (top == '0) || (&top);
  endfunction

  logic unused_hyp;
  assign unused_hyp = ^{hyp_state[7:6], hyp_state[4:3], hyp_state[1:0]};

  always_comb begin
    bypass       = hyp_state[2] | hyp_state[5];
    misalign     = |va[ALIGN_B-1:0];
    eff_va       = trunc_va(va, addr_mask_en);
    out_of_range = !sign_run_ok(eff_va);
  end
endmodule

// File: rtl/ixl_resolve.sv
module ixl_resolve
  import ixl_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic            req_valid,
  input  logic            bypass,
  input  logic            misalign,
  input  logic            out_of_range,
  input  logic            priv_mode,
  input  logic [PA_W-1:0] va_low,
  input  logic            tlb_hit,
  input  logic [PA_W-1:0] tlb_pa,
  input  logic [PA_W-1:0] tlb_off_mask,
  input  logic            tlb_priv,
  output logic            lookup,
  output fault_e          fault,
  output logic [PA_W-1:0] pa
);
  function automatic logic [PA_W-1:0] join_pa(logic [PA_W-1:0] frame,
                                              logic [PA_W-1:0] omask,
                                              logic [PA_W-1:0] v);
    return (frame & ~omask) | (v & omask);
  endfunction

  always_comb begin
    lookup = 1'b0;
    fault  = FLT_NONE;
    pa     = '0;
    if (bypass) begin
      pa = va_low;
    end else if (misalign) begin
      fault = FLT_MISALIGN;
    end else if (out_of_range) begin
      fault = FLT_RANGE;
    end else begin
      lookup = req_valid;
      if (!tlb_hit)                  fault = FLT_MISS;
      else if (!priv_mode && tlb_priv) fault = FLT_PRIV;
      else                           pa = join_pa(tlb_pa, tlb_off_mask, va_low);
    end
  end
endmodule

// File: rtl/ixl_out_reg.sv
module ixl_out_reg
  import ixl_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  fault_e            fault,
  input  logic [PA_W-1:0]   pa,
  input  logic [CTX_W-1:0]  ctx_type,
  input  logic [ASI_W-1:0]  asi,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [FSR_W-1:0]  fsr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 3'd0;
      rsp_pa    <= '0;
      fsr       <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= fault;
        rsp_pa    <= (fault == FLT_NONE) ? pa : '0;
        if (fault != FLT_NONE) fsr <= fsr_pack(ctx_type, fault, asi);
      end
    end
  end
endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
  import ixl_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PA_W    = 40,
  parameter int VA_IMPL = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_va,
  input  logic [7:0]            hyp_state,
  input  logic                  priv_mode,
  input  logic                  addr_mask_en,
  input  logic [1:0]            ctx_type,
  input  logic [7:0]            asi,
  output logic                  tlb_req_valid,
  output logic [VA_W-1:0]       tlb_req_va,
  input  logic                  tlb_hit,
  input  logic [PA_W-1:0]       tlb_pa,
  input  logic [PA_W-1:0]       tlb_off_mask,
  input  logic                  tlb_priv,
  output logic                  rsp_valid,
  output logic [2:0]            rsp_fault,
  output logic [PA_W-1:0]       rsp_pa,
  output logic [23:0]           fsr
);
  logic            bypass_w;
  logic            misalign_w;
  logic            range_w;
  logic [VA_W-1:0] eff_va_w;
  logic            lookup_w;
  fault_e          fault_w;
  logic [PA_W-1:0] pa_w;
  logic            fault_now_w;

  ixl_precheck #(.VA_W(VA_W), .VA_IMPL(VA_IMPL)) u_pre (
    .va           (req_va),
    .hyp_state    (hyp_state),
    .addr_mask_en (addr_mask_en),
    .bypass       (bypass_w),
    .misalign     (misalign_w),
    .out_of_range (range_w),
    .eff_va       (eff_va_w)
  );

  ixl_resolve #(.PA_W(PA_W)) u_res (
    .req_valid    (req_valid),
    .bypass       (bypass_w),
    .misalign     (misalign_w),
    .out_of_range (range_w),
    .priv_mode    (priv_mode),
    .va_low       (req_va[PA_W-1:0]),
    .tlb_hit      (tlb_hit),
    .tlb_pa       (tlb_pa),
    .tlb_off_mask (tlb_off_mask),
    .tlb_priv     (tlb_priv),
    .lookup       (lookup_w),
    .fault        (fault_w),
    .pa           (pa_w)
  );

  assign tlb_req_valid = lookup_w;
  assign tlb_req_va    = eff_va_w;
  assign fault_now_w   = req_valid && (fault_w != FLT_NONE);

  ixl_out_reg #(.PA_W(PA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .fault     (fault_w),
    .pa        (pa_w),
    .ctx_type  (ctx_type),
    .asi       (asi),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa),
    .fsr       (fsr)
  );
endmodule

// File: rtl/ifetch_xlate_chk.sv
module ifetch_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        rsp_valid,
  input logic [2:0]  rsp_fault,
  input logic [23:0] fsr,
  input logic        bypass,
  input logic        misalign,
  input logic        any_fault,
  input logic        tlb_req_valid
);
  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R11
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R11
  fault_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd4));
  // R10
  fsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_fault |=> $stable(fsr));
  // R1
  bypass_no_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !tlb_req_valid);
  // R2
  misalign_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bypass && misalign) |=> (rsp_fault == 3'd1));
  // R8
  fsr_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr[3:0] == 4'd0) && (fsr[15:14] == 2'd0));
endmodule

bind ifetch_xlate ifetch_xlate_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .fsr           (fsr),
  .bypass        (bypass_w),
  .misalign      (misalign_w),
  .any_fault     (fault_now_w),
  .tlb_req_valid (tlb_req_valid)
);

// File: tb/ifetch_xlate_bench.sv
module ifetch_xlate_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [63:0] req_va = 0;
  logic [7:0]  hyp_state = 0;
  logic        priv_mode = 0;
  logic        addr_mask_en = 0;
  logic [1:0]  ctx_type = 0;
  logic [7:0]  asi = 0;
  logic        tlb_req_valid;
  logic [63:0] tlb_req_va;
  logic        tlb_hit = 0;
  logic [39:0] tlb_pa = 0;
  logic [39:0] tlb_off_mask = 0;
  logic        tlb_priv = 0;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [39:0] rsp_pa;
  logic [23:0] fsr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  longint unsigned model_fsr = 0;

  ifetch_xlate u_ifetch_xlate (.*);

  always #4 clk = ~clk;

  task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Behavioural reference: returns code, physical address, lookup flag, key
  task automatic model(output int code, output longint unsigned pa,
                       output bit look, output longint unsigned key);
    longint unsigned v;
    longint unsigned hi;
    code = 0; pa = 0; look = 0;
    v = req_va;
    if (addr_mask_en) v = v % (64'd1 << 32);
    key = v;
    hi = v >> 47;
    if (hyp_state[2] || hyp_state[5]) begin
      pa = req_va % (64'd1 << 40);
      return;
    end
    if (req_va % 8 != 0) begin code = 1; return; end
    if (hi != 0 && hi != 64'h1FFFF) begin code = 2; return; end
    look = 1;
    if (!tlb_hit) begin code = 3; return; end
    if (tlb_priv && !priv_mode) begin code = 4; return; end
    pa = (longint'(tlb_pa) & ~longint'(tlb_off_mask) & 64'hFF_FFFF_FFFF)
       | (req_va & longint'(tlb_off_mask));
  endtask

  function automatic longint unsigned fsr_word(int code);
    int ft;
    int se;
    case (code)
      1: ft = 8;
      2: ft = 2;
      3: ft = 4;
      default: ft = 1;
    endcase
    se = (code == 2) ? 1 : 0;
    return longint'(ctx_type) * 16 + se * 64 + ft * 128 + longint'(asi) * 65536;
  endfunction

  task automatic do_req(string tag, logic [63:0] va, logic [7:0] hs, bit pm,
                        bit me, logic [1:0] cx, logic [7:0] as, bit hit,
                        logic [39:0] fr, logic [39:0] om, bit tp);
    int code;
    longint unsigned pa;
    longint unsigned key;
    bit look;
    @(negedge clk);
    req_valid = 1; req_va = va; hyp_state = hs; priv_mode = pm;
    addr_mask_en = me; ctx_type = cx; asi = as; tlb_hit = hit;
    tlb_pa = fr; tlb_off_mask = om; tlb_priv = tp;
    model(code, pa, look, key);
    #1;
    chk(tlb_req_valid == look, {tag, " lookup"}, tlb_req_valid, look);
    if (look) chk(tlb_req_va == key, {tag, " key"}, tlb_req_va, key);
    if (code != 0) model_fsr = fsr_word(code);
    @(negedge clk);
    chk(rsp_valid == 1, {tag, " R11 valid"}, rsp_valid, 1);
    chk(rsp_fault == code[2:0], {tag, " code"}, rsp_fault, code);
    chk(rsp_pa == pa[39:0], {tag, " pa"}, rsp_pa, pa);
    chk(fsr == model_fsr[23:0], {tag, " fsr"}, fsr, model_fsr);
    req_valid = 0;
  endtask

  task automatic idle_chk(string tag);
    @(negedge clk);
    chk(rsp_valid == 0, {tag, " R11 idle"}, rsp_valid, 0);
    chk(fsr == model_fsr[23:0], {tag, " R10 hold"}, fsr, model_fsr);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R11 reset valid", rsp_valid, 0);
    chk(fsr == 0, "R10 reset fsr", fsr, 0);
    rst_n = 1;
    // R7 success
    do_req("R7 ok", 64'h0000_1234_5678_A008, 0, 0, 0, 1, 8'h10, 1,
           40'h00_ABCD_E000, 40'h1FFF, 0);
    // R1 bypass, misaligned and out of range address
    do_req("R1 bypass2", 64'h8000_0055_0000_1003, 8'h04, 0, 0, 0, 0, 0, 0, 0, 0);
    do_req("R1 bypass5", 64'hFFFF_FFAB_CDEF_0127, 8'h20, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2 misaligned
    do_req("R2 misalign", 64'h0000_0000_0040_0004, 8'h01, 0, 0, 2, 8'h80, 1, 0, 40'hFFF, 0);
    idle_chk("R10 after fault");
    // R9 misaligned and out of range
    do_req("R9 order align", 64'h1234_0000_0000_0002, 0, 0, 0, 3, 8'h04, 1, 0, 0, 0);
    // R4 range
    do_req("R4 range", 64'h0001_0000_0000_0000, 0, 1, 0, 1, 8'h19, 1, 0, 0, 0);
    // R3 mask rescues range
    do_req("R3 mask", 64'hDEAD_0000_8000_2010, 0, 0, 1, 0, 8'h22, 1,
           40'h12_3450_0000, 40'hFFFF, 0);
    // R5 miss
    do_req("R5 miss", 64'hFFFF_8000_0000_0000, 0, 0, 0, 2, 8'h2A, 0, 0, 0, 1);
    // R9 miss beats privilege
    do_req("R9 order miss", 64'h0000_0000_0000_1000, 0, 0, 0, 1, 8'h33, 0, 0, 0, 1);
    // R6 privilege
    do_req("R6 priv", 64'h0000_7FFF_FFFF_F000, 0, 0, 0, 3, 8'h58, 1, 40'h1000, 40'hFFF, 1);
    do_req("R6 priv ok", 64'h0000_7FFF_FFFF_F018, 0, 1, 0, 3, 8'h58, 1,
           40'hFF_FFFF_F000, 40'hFFF, 1);
    // R10 success after fault keeps the word
    do_req("R10 hold", 64'h0000_0000_0001_0000, 0, 0, 0, 0, 8'h01, 1, 40'h5_0000, 40'hFFFF, 0);
    idle_chk("R10 idle");
    // R8 field positions swept through random mixtures
    for (int i = 0; i < 400; i++) begin
      logic [63:0] v;
      logic [7:0] hs;
      int sel;
      v = {$urandom, $urandom};
      sel = $urandom_range(0, 3);
      if (sel == 0) v[63:47] = '0;
      else if (sel == 1) v[63:47] = '1;
      if ($urandom_range(0, 2) != 0) v[2:0] = 0;
      hs = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'($urandom) & 8'hDB;
      do_req("R8 mix", v, hs, 1'($urandom), 1'($urandom_range(0, 3) == 0),
             2'($urandom), 8'($urandom), 1'($urandom_range(0, 4) != 0),
             40'({$urandom, $urandom}), 40'((64'd1 << (13 + 3 * $urandom_range(0, 3))) - 1),
             1'($urandom));
      if ($urandom_range(0, 3) == 0) idle_chk("R10 mix idle");
    end
    finish_run();
  end
endmodule